// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block moves data for four DMA channels. Each channel holds a 32-bit address, a 16-bit transfer count, a mode byte, a bit in a shared working mask and a sticky bit in a status vector. A pulse on the step input starts one service pass. The pass visits channels 0 to 3 in that order. For each channel whose working bit is set it performs exactly one transfer, then decrements that channel's count and moves its address by one.

A transfer is one of three kinds, chosen by the channel's mode. A verify transfer reads the channel's I/O port and throws the data away. An I/O-to-memory transfer reads the port and writes that byte to memory at the channel's address. A memory-to-I/O transfer reads memory at that address and writes the byte to the port. Memory accesses use a request/acknowledge handshake. Each channel has its own I/O read strobe, I/O write strobe and end-of-transfer pulse.

A channel whose count is already zero when its slot begins has reached terminal count. It still performs that slot's transfer. In the same slot it leaves the working mask and sets its status bit. Channels are programmed through a plain load port. A build option limits address stepping to the low 16 bits.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the working mask, the status vector and every channel's address, count and mode read as zero. busy_o is low, and no memory request, I/O strobe or end-of-transfer pulse is active.
- R2: A load strobe taken while the block is idle writes the selected channel's address, count and mode, all of which can be read back, and sets that channel's working bit. A load strobe taken while a pass is running (busy_o high) is ignored.
- R3: A step pulse with an all-zero working mask starts no memory request and no I/O strobe. It produces one pass_done_o pulse.
- R4: Within a pass, active channels are served in ascending index order. At most one of the eight I/O strobes and the memory request is high in any cycle.
- R5: If an active channel's count is zero at the start of its slot, that slot sets its status bit and clears its working bit. It raises its eot_o bit for exactly one cycle, and the count becomes 0xFFFF. The slot's transfer and address step still take place.
- R6: Every other served channel has its count reduced by exactly one per pass.
- R7: Mode bits [3:2] = 00 selects verify. The block pulses the channel's I/O read strobe for one cycle, makes no memory request and does not write the port.
- R8: Mode bits [3:2] = 01 selects I/O to memory. The I/O read strobe comes first, then a memory write of the byte just read, at the channel's current address. The request, write flag, address and data are held until mem_ack_i is sampled high.
- R9: Mode bits [3:2] = 10 or 11 selects memory to I/O. A memory read at the current address is held until acknowledged. Then the channel's I/O write strobe is pulsed with the byte returned on mem_rdata_i.
- R10: When mode bit 5 is set, the address decreases by one after each transfer. Otherwise it increases by one, with the full 32-bit address wrapping.
- R11: With ADDR_STEP_LOW_ONLY set, only the low ADDR_STEP_W bits (16 by default) step and wrap, and the upper address bits stay unchanged.
- R12: A channel whose working bit is clear during a pass gets no strobe, and its address, count and status stay as they were.
- R13: A status bit stays set until a stat_clr_i strobe for that bit. When a terminal-count set and a clear for the same bit fall in the same cycle, the set wins.
- R14: busy_o is high from the cycle after the step pulse until the pass completes. pass_done_o is high for exactly one cycle at the end of each pass, and busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Starts one service pass when idle |
| ld_en_i | input | 1 | Load strobe for one channel |
| ld_ch_i | input | 2 | Channel to load |
| ld_addr_i | input | 32 | Start address to load |
| ld_cnt_i | input | 16 | Count to load |
| ld_mode_i | input | 8 | Mode byte to load |
| stat_clr_i | input | 4 | Per-channel status clear strobes |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| io_rd_o | output | 4 | Per-channel I/O read strobe |
| io_wr_o | output | 4 | Per-channel I/O write strobe |
| io_rdata_i | input | 8 | Data from the strobed I/O port |
| io_wdata_o | output | 8 | Data to the strobed I/O port |
| eot_o | output | 4 | Per-channel end-of-transfer pulse |
| busy_o | output | 1 | A pass is running |
| pass_done_o | output | 1 | One-cycle pulse when a pass finishes |
| work_o | output | 4 | Working mask |
| stat_o | output | 4 | Sticky status vector |
| rd_sel_i | input | 2 | Channel selected for readback |
| rd_addr_o | output | 32 | Registered address of the selected channel |
| rd_cnt_o | output | 16 | Registered count of the selected channel |
| rd_mode_o | output | 8 | Registered mode of the selected channel |

## Verification
The terminal-count status set and the host status clear can land on the same flop in the same cycle. To provoke this, the bench holds the clear strobe for a channel loaded with a zero count until that channel's end-of-transfer pulse appears. The test is judged by the status bit still being set after the strobe is released, then staying set, and then dropping on a later lone clear. The second collision is a load strobe that arrives while a pass is running. It is judged by reading back the target channel's count and address and the working mask after the pass ends.

// File: rtl/dma_xfer_seq_pkg.sv
package dma_xfer_seq_pkg;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'd0,
    XF_IO2MEM = 2'd1,
    XF_MEM2IO = 2'd2
  } xfer_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SCAN = 3'd1,
    ST_IORD = 3'd2,
    ST_MEM  = 3'd3,
    ST_IOWR = 3'd4,
    ST_STEP = 3'd5,
    ST_FIN  = 3'd6
  } seq_state_e;

  localparam int MODE_KIND_LSB = 2;
  localparam int MODE_DOWN_BIT = 5;

  function automatic xfer_e kind_of(input logic [1:0] field);
    case (field)
      2'b00:   return XF_VERIFY;
      2'b01:   return XF_IO2MEM;
      default: return XF_MEM2IO;
    endcase
  endfunction

endpackage

// File: rtl/dma_xfer_seq_addr_step.sv
module dma_xfer_seq_addr_step #(
  parameter int ADDR_W      = 32,
  parameter int STEP_W      = 16,
  parameter bit LOW_ONLY    = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o
);

  generate
    if (LOW_ONLY && (STEP_W < ADDR_W)) begin : g_low
      localparam logic [STEP_W-1:0] ONE_L = STEP_W'(1);
      logic [STEP_W-1:0] low_n;
      always_comb begin
        if (down_i) low_n = addr_i[STEP_W-1:0] - ONE_L;
        else        low_n = addr_i[STEP_W-1:0] + ONE_L;
        addr_o = {addr_i[ADDR_W-1:STEP_W], low_n};
      end
    end else begin : g_full
      localparam logic [ADDR_W-1:0] ONE_F = ADDR_W'(1);
      always_comb begin
        if (down_i) addr_o = addr_i - ONE_F;
        else        addr_o = addr_i + ONE_F;
      end
    end
  endgenerate

endmodule

// File: rtl/dma_xfer_seq_chregs.sv
module dma_xfer_seq_chregs #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 8,
  parameter int CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ld_en,
  input  logic [CH_W-1:0]                ld_ch,
  input  logic [ADDR_W-1:0]              ld_addr,
  input  logic [CNT_W-1:0]               ld_cnt,
  input  logic [MODE_W-1:0]              ld_mode,
  input  logic [CH_W-1:0]                upd_ch,
  input  logic                           cnt_we,
  input  logic [CNT_W-1:0]               cnt_val,
  input  logic                           addr_we,
  input  logic [ADDR_W-1:0]              addr_val,
  input  logic                           tc_set,
  input  logic [NUM_CH-1:0]              stat_clr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  addr_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_q,
  output logic [NUM_CH-1:0][MODE_W-1:0]  mode_q,
  output logic [NUM_CH-1:0]              work_q,
  output logic [NUM_CH-1:0]              stat_q
);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit_ld;
      logic hit_up;
      assign hit_ld = ld_en && (ld_ch == CH_W'(g));
      assign hit_up = (upd_ch == CH_W'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q[g] <= '0;
          cnt_q[g]  <= '0;
          mode_q[g] <= '0;
          work_q[g] <= 1'b0;
        end else if (hit_ld) begin
          addr_q[g] <= ld_addr;
          cnt_q[g]  <= ld_cnt;
          mode_q[g] <= ld_mode;
          work_q[g] <= 1'b1;
        end else begin
          if (cnt_we && hit_up)  cnt_q[g]  <= cnt_val;
          if (addr_we && hit_up) addr_q[g] <= addr_val;
          if (tc_set && hit_up)  work_q[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) stat_q[g] <= 1'b0;
        else     stat_q[g] <= (stat_q[g] && !stat_clr[g]) || (tc_set && hit_up);
      end
    end
  endgenerate

endmodule

// File: rtl/dma_xfer_seq_engine.sv
module dma_xfer_seq_engine
  import dma_xfer_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           step,
  input  logic [NUM_CH-1:0]              work_q,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_q,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  addr_q,
  input  xfer_e [NUM_CH-1:0]             kind_a,
  input  logic [NUM_CH-1:0]              down_a,
  input  logic                           mem_ack,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic [DATA_W-1:0]              io_rdata,
  output logic [ADDR_W-1:0]              cur_addr,
  output logic                           cur_down,
  output logic [CH_W-1:0]                upd_ch,
  output logic                           cnt_we,
  output logic [CNT_W-1:0]               cnt_val,
  output logic                           addr_we,
  output logic                           tc_set,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  output logic [NUM_CH-1:0]              io_rd,
  output logic [NUM_CH-1:0]              io_wr,
  output logic [DATA_W-1:0]              io_wdata,
  output logic [NUM_CH-1:0]              eot,
  output logic                           busy,
  output logic                           pass_done
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  seq_state_e          state_q;
  logic [CH_W-1:0]     ch_q;
  xfer_e               kind_q;
  logic [DATA_W-1:0]   data_q;
  logic [NUM_CH-1:0]   eot_q;
  logic [NUM_CH-1:0]   ch_oh;
  logic                slot_live;
  logic                at_zero;

  assign ch_oh     = NUM_CH'(1) << ch_q;
  assign slot_live = (state_q == ST_SCAN) && work_q[ch_q];
  assign at_zero   = (cnt_q[ch_q] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      kind_q  <= XF_VERIFY;
      data_q  <= '0;
      eot_q   <= '0;
    end else begin
      eot_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (step) begin
            ch_q    <= '0;
            state_q <= (|work_q) ? ST_SCAN : ST_FIN;
          end
        end
        ST_SCAN: begin
          if (work_q[ch_q]) begin
            kind_q <= kind_a[ch_q];
            if (at_zero) eot_q <= ch_oh;
            state_q <= (kind_a[ch_q] == XF_MEM2IO) ? ST_MEM : ST_IORD;
          end else if (ch_q == LAST_CH) begin
            state_q <= ST_FIN;
          end else begin
            ch_q <= ch_q + 1'b1;
          end
        end
        ST_IORD: begin
          data_q  <= io_rdata;
          state_q <= (kind_q == XF_IO2MEM) ? ST_MEM : ST_STEP;
        end
        ST_MEM: begin
          if (mem_ack) begin
            if (kind_q == XF_MEM2IO) begin
              data_q  <= mem_rdata;
              state_q <= ST_IOWR;
            end else begin
              state_q <= ST_STEP;
            end
          end
        end
        ST_IOWR: state_q <= ST_STEP;
        ST_STEP: begin
          if (ch_q == LAST_CH) begin
            state_q <= ST_FIN;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cur_addr  = addr_q[ch_q];
    cur_down  = down_a[ch_q];
    upd_ch    = ch_q;
    cnt_we    = slot_live;
    cnt_val   = cnt_q[ch_q] - ONE_C;
    tc_set    = slot_live && at_zero;
    addr_we   = (state_q == ST_STEP);
    mem_req   = (state_q == ST_MEM);
    mem_we    = (state_q == ST_MEM) && (kind_q == XF_IO2MEM);
    mem_addr  = addr_q[ch_q];
    mem_wdata = data_q;
    io_rd     = (state_q == ST_IORD) ? ch_oh : '0;
    io_wr     = (state_q == ST_IOWR) ? ch_oh : '0;
    io_wdata  = data_q;
    eot       = eot_q;
    busy      = (state_q != ST_IDLE);
    pass_done = (state_q == ST_FIN);
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_seq_pkg::*;
#(
  parameter int NUM_CH             = 4,
  parameter int ADDR_W             = 32,
  parameter int CNT_W              = 16,
  parameter int DATA_W             = 8,
  parameter int MODE_W             = 8,
  parameter int ADDR_STEP_W        = 16,
  parameter bit ADDR_STEP_LOW_ONLY = 1'b0,
  localparam int CH_W              = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              ld_en_i,
  input  logic [CH_W-1:0]   ld_ch_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [CNT_W-1:0]  ld_cnt_i,
  input  logic [MODE_W-1:0] ld_mode_i,
  input  logic [NUM_CH-1:0] stat_clr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [NUM_CH-1:0] io_rd_o,
  output logic [NUM_CH-1:0] io_wr_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic [DATA_W-1:0] io_wdata_o,
  output logic [NUM_CH-1:0] eot_o,
  output logic              busy_o,
  output logic              pass_done_o,
  output logic [NUM_CH-1:0] work_o,
  output logic [NUM_CH-1:0] stat_o,
  input  logic [CH_W-1:0]   rd_sel_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [MODE_W-1:0] rd_mode_o
);

  logic [NUM_CH-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0][MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0]             work_q;
  logic [NUM_CH-1:0]             stat_q;
  xfer_e [NUM_CH-1:0]            kind_a;
  logic [NUM_CH-1:0]             down_a;

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_down;
  logic [ADDR_W-1:0] next_addr;
  logic [CH_W-1:0]   upd_ch;
  logic              cnt_we;
  logic [CNT_W-1:0]  cnt_val;
  logic              addr_we;
  logic              tc_set;
  logic              busy;
  logic              ld_take;

  assign ld_take = ld_en_i && !busy;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
      assign kind_a[g] = kind_of(mode_q[g][MODE_KIND_LSB +: 2]);
      assign down_a[g] = mode_q[g][MODE_DOWN_BIT];
    end
  endgenerate

  dma_xfer_seq_chregs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MODE_W (MODE_W),
    .CH_W   (CH_W)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_take),
    .ld_ch    (ld_ch_i),
    .ld_addr  (ld_addr_i),
    .ld_cnt   (ld_cnt_i),
    .ld_mode  (ld_mode_i),
    .upd_ch   (upd_ch),
    .cnt_we   (cnt_we),
    .cnt_val  (cnt_val),
    .addr_we  (addr_we),
    .addr_val (next_addr),
    .tc_set   (tc_set),
    .stat_clr (stat_clr_i),
    .addr_q   (addr_q),
    .cnt_q    (cnt_q),
    .mode_q   (mode_q),
    .work_q   (work_q),
    .stat_q   (stat_q)
  );

  dma_xfer_seq_addr_step #(
    .ADDR_W   (ADDR_W),
    .STEP_W   (ADDR_STEP_W),
    .LOW_ONLY (ADDR_STEP_LOW_ONLY)
  ) step_i0 (
    .addr_i (cur_addr),
    .down_i (cur_down),
    .addr_o (next_addr)
  );

  dma_xfer_seq_engine #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) eng_i (
    .clk       (clk),
    .rst       (rst),
    .step      (step_i),
    .work_q    (work_q),
    .cnt_q     (cnt_q),
    .addr_q    (addr_q),
    .kind_a    (kind_a),
    .down_a    (down_a),
    .mem_ack   (mem_ack_i),
    .mem_rdata (mem_rdata_i),
    .io_rdata  (io_rdata_i),
    .cur_addr  (cur_addr),
    .cur_down  (cur_down),
    .upd_ch    (upd_ch),
    .cnt_we    (cnt_we),
    .cnt_val   (cnt_val),
    .addr_we   (addr_we),
    .tc_set    (tc_set),
    .mem_req   (mem_req_o),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .io_rd     (io_rd_o),
    .io_wr     (io_wr_o),
    .io_wdata  (io_wdata_o),
    .eot       (eot_o),
    .busy      (busy),
    .pass_done (pass_done_o)
  );

  assign busy_o = busy;
  assign work_o = work_q;
  assign stat_o = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr_o <= '0;
      rd_cnt_o  <= '0;
      rd_mode_o <= '0;
    end else begin
      rd_addr_o <= addr_q[rd_sel_i];
      rd_cnt_o  <= cnt_q[rd_sel_i];
      rd_mode_o <= mode_q[rd_sel_i];
    end
  end

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic [NUM_CH-1:0] io_rd_o,
  input logic [NUM_CH-1:0] io_wr_o,
  input logic [NUM_CH-1:0] eot_o,
  input logic              busy_o,
  input logic              pass_done_o,
  input logic [NUM_CH-1:0] work_o,
  input logic [NUM_CH-1:0] stat_o,
  input logic [NUM_CH-1:0] stat_clr_i
);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mem_req_o && (io_rd_o == '0) && (io_wr_o == '0) && (eot_o == '0)));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({io_rd_o, io_wr_o, mem_req_o}));

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_done_single_R14: assert property (@(posedge clk) disable iff (rst)
    pass_done_o |=> (!pass_done_o && !busy_o));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
      assert_eot_status_R5: assert property (@(posedge clk) disable iff (rst)
        eot_o[n] |-> (stat_o[n] && !work_o[n]));

      assert_eot_single_R5: assert property (@(posedge clk) disable iff (rst)
        eot_o[n] |=> !eot_o[n]);

      assert_stat_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        (stat_o[n] && !stat_clr_i[n]) |=> stat_o[n]);
    end
  endgenerate

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .io_rd_o     (io_rd_o),
  .io_wr_o     (io_wr_o),
  .eot_o       (eot_o),
  .busy_o      (busy_o),
  .pass_done_o (pass_done_o),
  .work_o      (work_o),
  .stat_o      (stat_o),
  .stat_clr_i  (stat_clr_i)
);

// File: tb/dma_xfer_seq_tb_top.sv
module dma_xfer_seq_tb_top;

  localparam int E_IORD  = 0;
  localparam int E_IOWR  = 1;
  localparam int E_MEMWR = 2;
  localparam int E_MEMRD = 3;

  typedef struct packed {
    logic [1:0]  ch;
    logic [7:0]  mode;
    logic [31:0] addr;
    logic [15:0] cnt;
    logic [31:0] eaddr;
    logic [15:0] ecnt;
    logic        eeot;
    logic [1:0]  kind;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 8'h04, 32'h0000_1000, 16'h0003, 32'h0000_1001, 16'h0002, 1'b0, 2'd1},
    '{2'd1, 8'h08, 32'h0000_20FF, 16'h0001, 32'h0000_2100, 16'h0000, 1'b0, 2'd2},
    '{2'd2, 8'h00, 32'h0000_3000, 16'h0005, 32'h0000_3001, 16'h0004, 1'b0, 2'd0},
    '{2'd3, 8'h2C, 32'h0000_4000, 16'h0002, 32'h0000_3FFF, 16'h0001, 1'b0, 2'd2},
    '{2'd0, 8'h24, 32'h0001_0000, 16'h0000, 32'h0000_FFFF, 16'hFFFF, 1'b1, 2'd1},
    '{2'd1, 8'h04, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 16'hFFFF, 1'b1, 2'd1},
    '{2'd2, 8'h20, 32'h0000_0000, 16'h0007, 32'hFFFF_FFFF, 16'h0006, 1'b0, 2'd0},
    '{2'd3, 8'h0C, 32'h1234_5678, 16'h8000, 32'h1234_5679, 16'h7FFF, 1'b0, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_ch = '0;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_cnt = '0;
  logic [7:0]  ld_mode = '0;
  logic [3:0]  stat_clr = '0;
  logic [1:0]  rd_sel = '0;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  io_rdata;

  logic        mem_req, mem_we, busy, pass_done;
  logic [31:0] mem_addr, rd_addr;
  logic [7:0]  mem_wdata, io_wdata, rd_mode;
  logic [3:0]  io_rd, io_wr, eot, work, stat;
  logic [15:0] rd_cnt;

  logic        h_mem_req, h_mem_we, h_busy, h_pass_done;
  logic [31:0] h_mem_addr, h_rd_addr;
  logic [7:0]  h_mem_wdata, h_io_wdata, h_rd_mode;
  logic [3:0]  h_io_rd, h_io_wr, h_eot, h_work, h_stat;
  logic [15:0] h_rd_cnt;

  always #5 clk = ~clk;

  always_comb begin
    io_rdata = 8'h00;
    for (int i = 0; i < 4; i++) if (io_rd[i]) io_rdata = 8'hA0 + 8'(i);
  end

  dma_xfer_seq dut_i (
    .clk(clk), .rst(rst), .step_i(step), .ld_en_i(ld_en), .ld_ch_i(ld_ch),
    .ld_addr_i(ld_addr), .ld_cnt_i(ld_cnt), .ld_mode_i(ld_mode), .stat_clr_i(stat_clr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .io_rd_o(io_rd), .io_wr_o(io_wr),
    .io_rdata_i(io_rdata), .io_wdata_o(io_wdata), .eot_o(eot), .busy_o(busy),
    .pass_done_o(pass_done), .work_o(work), .stat_o(stat), .rd_sel_i(rd_sel),
    .rd_addr_o(rd_addr), .rd_cnt_o(rd_cnt), .rd_mode_o(rd_mode)
  );

  dma_xfer_seq #(.ADDR_STEP_LOW_ONLY(1'b1)) dut16_i (
    .clk(clk), .rst(rst), .step_i(step), .ld_en_i(ld_en), .ld_ch_i(ld_ch),
    .ld_addr_i(ld_addr), .ld_cnt_i(ld_cnt), .ld_mode_i(ld_mode), .stat_clr_i(stat_clr),
    .mem_req_o(h_mem_req), .mem_we_o(h_mem_we), .mem_addr_o(h_mem_addr),
    .mem_wdata_o(h_mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .io_rd_o(h_io_rd), .io_wr_o(h_io_wr), .io_rdata_i(io_rdata), .io_wdata_o(h_io_wdata),
    .eot_o(h_eot), .busy_o(h_busy), .pass_done_o(h_pass_done), .work_o(h_work),
    .stat_o(h_stat), .rd_sel_i(rd_sel), .rd_addr_o(h_rd_addr), .rd_cnt_o(h_rd_cnt),
    .rd_mode_o(h_rd_mode)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int mem_lat = 0;
  int lat_cnt = 0;
  int ev_n = 0;
  int done_cnt = 0;
  logic [3:0] eot_seen = '0;
  int          ev_kind [0:63];
  int          ev_ch   [0:63];
  logic [31:0] ev_addr [0:63];
  logic [7:0]  ev_data [0:63];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int oh_idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (lat_cnt >= mem_lat) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem_addr[7:0] ^ 8'h5A;
          lat_cnt   <= 0;
          if (ev_n < 64) begin
            ev_kind[ev_n] = mem_we ? E_MEMWR : E_MEMRD;
            ev_ch[ev_n]   = -1;
            ev_addr[ev_n] = mem_addr;
            ev_data[ev_n] = mem_wdata;
            ev_n++;
          end
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
      if (|io_rd && ev_n < 64) begin
        ev_kind[ev_n] = E_IORD; ev_ch[ev_n] = oh_idx(io_rd);
        ev_addr[ev_n] = '0; ev_data[ev_n] = io_rdata; ev_n++;
      end
      if (|io_wr && ev_n < 64) begin
        ev_kind[ev_n] = E_IOWR; ev_ch[ev_n] = oh_idx(io_wr);
        ev_addr[ev_n] = '0; ev_data[ev_n] = io_wdata; ev_n++;
      end
      eot_seen = eot_seen | eot;
      if (pass_done) done_cnt++;
    end
  end

  task automatic summary_and_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary_and_end();
    end
  end

  task automatic clear_log();
    ev_n = 0; done_cnt = 0; eot_seen = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step = 1'b0; ld_en = 1'b0; stat_clr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_log();
  endtask

  task automatic load(input logic [1:0] c, input logic [31:0] a, input logic [15:0] n, input logic [7:0] m);
    @(negedge clk);
    ld_en = 1'b1; ld_ch = c; ld_addr = a; ld_cnt = n; ld_mode = m;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_pass();
    @(negedge clk);
    clear_log();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic wait_pass();
    for (int k = 0; k < 5000 && done_cnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic readback(input logic [1:0] c);
    @(negedge clk);
    rd_sel = c;
    @(negedge clk);
  endtask

  initial begin
    do_reset();

    // R1: reset state
    chk(work == 4'h0, "R1 work", 64'(work), 64'h0);
    chk(stat == 4'h0, "R1 stat", 64'(stat), 64'h0);
    chk(!busy && !mem_req && io_rd == 0 && io_wr == 0 && eot == 0, "R1 quiet",
        64'({busy, mem_req, io_rd, io_wr, eot}), 64'h0);
    readback(2'd2);
    chk(rd_addr == 0 && rd_cnt == 0 && rd_mode == 0, "R1 regs", 64'({rd_addr, rd_cnt}), 64'h0);

    // R3: empty pass
    start_pass();
    wait_pass();
    chk(ev_n == 0, "R3 no activity", 64'(ev_n), 64'h0);
    chk(done_cnt == 1, "R3 done pulse", 64'(done_cnt), 64'h1);

    // Vector table: R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      vec_t t;
      t = VECS[v];
      do_reset();
      mem_lat = v % 3;
      load(t.ch, t.addr, t.cnt, t.mode);
      start_pass();
      wait_pass();
      if (t.kind == 2'd0) begin
        chk(ev_n == 1 && ev_kind[0] == E_IORD && ev_ch[0] == int'(t.ch), "R7 verify",
            64'(ev_n), 64'h1);
      end else if (t.kind == 2'd1) begin
        chk(ev_n == 2 && ev_kind[0] == E_IORD && ev_ch[0] == int'(t.ch) && ev_kind[1] == E_MEMWR,
            "R8 sequence", 64'(ev_n), 64'h2);
        chk(ev_addr[1] == t.addr && ev_data[1] == (8'hA0 + 8'(t.ch)), "R8 write",
            64'({ev_addr[1], ev_data[1]}), 64'({t.addr, 8'hA0 + 8'(t.ch)}));
      end else begin
        chk(ev_n == 2 && ev_kind[0] == E_MEMRD && ev_addr[0] == t.addr && ev_kind[1] == E_IOWR &&
            ev_ch[1] == int'(t.ch), "R9 sequence", 64'(ev_addr[0]), 64'(t.addr));
        chk(ev_data[1] == (t.addr[7:0] ^ 8'h5A), "R9 data", 64'(ev_data[1]),
            64'(t.addr[7:0] ^ 8'h5A));
      end
      readback(t.ch);
      chk(rd_addr == t.eaddr, "R10 address step", 64'(rd_addr), 64'(t.eaddr));
      chk(rd_cnt == t.ecnt, t.eeot ? "R5 count wrap" : "R6 count", 64'(rd_cnt), 64'(t.ecnt));
      chk(rd_mode == t.mode, "R2 mode", 64'(rd_mode), 64'(t.mode));
      chk(eot_seen == (4'(t.eeot) << t.ch), "R5 eot", 64'(eot_seen), 64'(4'(t.eeot) << t.ch));
      chk(stat == (4'(t.eeot) << t.ch) && work == (4'(!t.eeot) << t.ch), "R5 stat/work",
          64'({stat, work}), 64'({4'(t.eeot) << t.ch, 4'(!t.eeot) << t.ch}));
    end

    // R4 ordering and R14 pass end
    do_reset();
    mem_lat = 0;
    load(2'd3, 32'h30, 16'd1, 8'h00);
    load(2'd1, 32'h10, 16'd1, 8'h00);
    load(2'd0, 32'h00, 16'd1, 8'h00);
    load(2'd2, 32'h20, 16'd1, 8'h00);
    start_pass();
    chk(busy, "R14 busy during pass", 64'(busy), 64'h1);
    wait_pass();
    chk(ev_n == 4, "R4 count", 64'(ev_n), 64'h4);
    for (int i = 0; i < 4; i++)
      chk(ev_ch[i] == i, "R4 order", 64'(ev_ch[i]), 64'(i));
    chk(done_cnt == 1 && !busy, "R14 done", 64'({done_cnt[7:0], 7'd0, busy}), 64'h100);

    // R12 inactive channel untouched
    do_reset();
    load(2'd0, 32'h100, 16'd0, 8'h00);
    load(2'd2, 32'h200, 16'd5, 8'h00);
    start_pass();
    wait_pass();
    chk(work == 4'b0100 && stat == 4'b0001, "R5 first pass", 64'({stat, work}), 64'h14);
    start_pass();
    wait_pass();
    chk(ev_n == 1 && ev_ch[0] == 2, "R12 only ch2 served", 64'(ev_n), 64'h1);
    readback(2'd0);
    chk(rd_addr == 32'h101 && rd_cnt == 16'hFFFF, "R12 ch0 unchanged",
        64'({rd_addr, rd_cnt}), 64'({32'h101, 16'hFFFF}));
    chk(stat == 4'b0001, "R12 status unchanged", 64'(stat), 64'h1);
    readback(2'd2);
    chk(rd_addr == 32'h202 && rd_cnt == 16'd3, "R6 ch2 two passes",
        64'({rd_addr, rd_cnt}), 64'({32'h202, 16'd3}));

    // R2 load works idle, ignored busy
    do_reset();
    mem_lat = 20;
    load(2'd0, 32'h50, 16'd4, 8'h08);
    readback(2'd0);
    chk(rd_addr == 32'h50 && rd_cnt == 16'd4 && work == 4'b0001, "R2 idle load",
        64'({rd_addr, rd_cnt}), 64'({32'h50, 16'd4}));
    start_pass();
    load(2'd3, 32'h77, 16'd9, 8'h00);
    wait_pass();
    readback(2'd3);
    chk(rd_addr == 0 && rd_cnt == 0 && work == 4'b0001, "R2 busy load ignored",
        64'({rd_addr, rd_cnt, work}), 64'h1);
    mem_lat = 0;

    // R13 set wins over same-cycle clear, then sticky, then cleared
    do_reset();
    load(2'd1, 32'h0, 16'd0, 8'h00);
    @(negedge clk);
    clear_log();
    step = 1'b1;
    stat_clr = 4'b0010;
    @(negedge clk);
    step = 1'b0;
    for (int k = 0; k < 100 && !eot[1]; k++) @(negedge clk);
    stat_clr = 4'b0000;
    wait_pass();
    chk(stat[1] == 1'b1, "R13 set wins", 64'(stat), 64'h2);
    repeat (5) @(negedge clk);
    chk(stat[1] == 1'b1, "R13 sticky", 64'(stat), 64'h2);
    stat_clr = 4'b0010;
    @(negedge clk);
    stat_clr = 4'b0000;
    @(negedge clk);
    chk(stat == 4'b0000, "R13 cleared", 64'(stat), 64'h0);

    // R11 low-16 stepping variant
    do_reset();
    load(2'd0, 32'h1234_FFFF, 16'd2, 8'h00);
    load(2'd1, 32'hABCD_0000, 16'd2, 8'h20);
    start_pass();
    wait_pass();
    readback(2'd0);
    chk(rd_addr == 32'h1235_0000, "R10 full carry", 64'(rd_addr), 64'h1235_0000);
    chk(h_rd_addr == 32'h1234_0000, "R11 low wrap up", 64'(h_rd_addr), 64'h1234_0000);
    readback(2'd1);
    chk(rd_addr == 32'hABCC_FFFF, "R10 full borrow", 64'(rd_addr), 64'hABCC_FFFF);
    chk(h_rd_addr == 32'hABCD_FFFF, "R11 low wrap down", 64'(h_rd_addr), 64'hABCD_FFFF);

    summary_and_end();
  end

endmodule